// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the controller side of a parallel NOR-style flash. After a program or erase command has been sent, the host pulses `start`. The poller then reads the device's 8-bit status byte over a request/acknowledge memory bus and decides whether the embedded operation has ended. It does not wait for a ready flag. It compares the toggle bit (bit 6) between reads that follow each other: a bit that stops flipping means the operation has completed. If the toggle bit is still flipping while the timeout flag (bit 5) is set, the poller takes one more pair of reads. This confirmation covers the case where the device finished just as the flag rose.

A confirmed failure, or a device that never settles within a programmable number of read pairs, makes the poller write the reset command 0xF0 to the device. It reports failure only after that write has been acknowledged. The host sees a 2-bit result code and a one-cycle done strobe. An abort input drops everything and returns the poller to idle with no stored toggle history.

Top module: `flash_tgl_poller`

## Requirements
- R1: Out of reset, `mem_req` is 0, `res_valid` is 0 and `res_code` is 2'b00 (idle).
- R2: After `start`, the poller makes two status reads. If bit 6 of the two reads is equal, it reports `res_code`=2'b10 (pass) with a one-cycle `res_valid` and makes no write.
- R3: If bit 6 differs and bit 5 of the second read is 0, the poller makes a further pair of reads. While it works, `res_code` is 2'b01 (busy).
- R4: If bit 6 differs and bit 5 of the second read is 1, the poller makes exactly two more reads. If bit 6 is equal across those two reads, it reports pass.
- R5: If bit 6 still differs in the confirming pair, the poller makes one write with `mem_we`=1 and `mem_wdata`=0xF0. Only after that write is acknowledged does it report `res_code`=2'b11 (fail).
- R6: Each transfer keeps `mem_req`, `mem_we` and `mem_wdata` steady until `mem_ack` is seen, and the poller advances only after that acknowledge.
- R7: `abort` takes the poller to idle on the next cycle: `mem_req` low and `res_code` 2'b00. The next `start` begins again with a fresh pair of two reads.
- R8: With `max_polls`=N>0, the N-th first-stage pair that still toggles with bit 5 at 0 causes the reset write and a fail. With N=0 there is no limit.
- R9: A `start` while busy is ignored. After completion, `res_code` holds its result until the next accepted `start`.
- R10: Only bits 6 and 5 of the status byte affect the decision. All other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a status evaluation (pulse) |
| abort | input | 1 | Abandon polling, return to idle |
| max_polls | input | CW | Read-pair limit, 0 = unlimited |
| mem_req | output | 1 | Bus transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wdata | output | DW | Write data byte |
| mem_rdata | input | DW | Read data byte (status) |
| mem_ack | input | 1 | Transfer acknowledge |
| res_code | output | 2 | 00 idle, 01 busy, 10 pass, 11 fail |
| res_valid | output | 1 | One-cycle done strobe |

## Verification
The bench drives scripted status byte streams and aims at the confirmation path in both directions. A poller that skipped the re-check would report fail when the device had just finished. A poller that used a single read would report pass early. A directed case aborts after one read and restarts: a design that reused the stale stored bit would finish after a single new read instead of two. Other cases check the pair limit at exactly N pairs and the unlimited setting, and confirm that noise in the unrelated status bits cannot change the verdict.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  typedef enum logic [1:0] {
    RES_IDLE = 2'b00,
    RES_BUSY = 2'b01,
    RES_PASS = 2'b10,
    RES_FAIL = 2'b11
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_A,
    S_RD_B,
    S_RC_A,
    S_RC_B,
    S_RST_W
  } st_e;
endpackage

// File: rtl/ftp_bus_port.sv
module ftp_bus_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          go,
  input  logic          go_we,
  input  logic [DW-1:0] go_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          xfer_done,
  output logic [DW-1:0] rd_byte
);
  always_ff @(posedge clk) begin
    if (rst || abort) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      xfer_done <= 1'b0;
      rd_byte   <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (mem_req && mem_ack) begin
        mem_req   <= 1'b0;
        mem_we    <= 1'b0;
        xfer_done <= 1'b1;
        rd_byte   <= mem_rdata;
      end else if (go && !mem_req) begin
        mem_req   <= 1'b1;
        mem_we    <= go_we;
        mem_wdata <= go_wdata;
      end
    end
  end
endmodule

// File: rtl/ftp_pair_ctr.sv
module ftp_pair_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  localparam int XW = CW + 1;
  logic [CW-1:0] cnt;
  logic [XW-1:0] nxt;

  assign nxt = {1'b0, cnt} + XW'(1);
  assign hit = (limit != '0) && (nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (inc)    cnt <= nxt[CW-1:0];
  end
endmodule

// File: rtl/flash_tgl_poller.sv
module flash_tgl_poller
  import ftp_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          CW      = 16,
  parameter int          TGL_BIT = 6,
  parameter int          TMO_BIT = 5,
  parameter logic [7:0]  RST_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic [CW-1:0] max_polls,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic [1:0]    res_code,
  output logic          res_valid
);
  st_e           st;
  logic          tgl_q;
  logic [CW-1:0] lim_q;
  logic          xfer_done;
  logic [DW-1:0] rd_byte;
  logic          in_bus, go, lim_hit, same, tmo, cnt_inc, cnt_clr;

  assign in_bus  = (st != S_IDLE);
  assign go      = in_bus && !mem_req && !xfer_done;
  assign same    = (rd_byte[TGL_BIT] == tgl_q);
  assign tmo     = rd_byte[TMO_BIT];
  assign cnt_clr = (st == S_IDLE) && start;
  assign cnt_inc = (st == S_RD_B) && xfer_done && !same && !tmo && !lim_hit;

  ftp_bus_port #(.DW(DW)) port_i (
    .clk(clk), .rst(rst), .abort(abort),
    .go(go), .go_we(st == S_RST_W), .go_wdata(DW'(RST_CMD)),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .xfer_done(xfer_done), .rd_byte(rd_byte)
  );

  ftp_pair_ctr #(.CW(CW)) ctr_i (
    .clk(clk), .rst(rst), .clr(cnt_clr || abort),
    .inc(cnt_inc), .limit(lim_q), .hit(lim_hit)
  );

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st        <= S_IDLE;
      tgl_q     <= 1'b0;
      res_code  <= RES_IDLE;
      res_valid <= 1'b0;
      if (rst) lim_q <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st       <= S_RD_A;
          tgl_q    <= 1'b0;
          res_code <= RES_BUSY;
          lim_q    <= max_polls;
        end
        S_RD_A: if (xfer_done) begin
          tgl_q <= rd_byte[TGL_BIT];
          st    <= S_RD_B;
        end
        S_RC_A: if (xfer_done) begin
          tgl_q <= rd_byte[TGL_BIT];
          st    <= S_RC_B;
        end
        S_RD_B: if (xfer_done) begin
          if (same) begin
            res_code  <= RES_PASS;
            res_valid <= 1'b1;
            st        <= S_IDLE;
          end else if (tmo)     st <= S_RC_A;
          else if (lim_hit)     st <= S_RST_W;
          else                  st <= S_RD_A;
        end
        S_RC_B: if (xfer_done) begin
          if (same) begin
            res_code  <= RES_PASS;
            res_valid <= 1'b1;
            st        <= S_IDLE;
          end else st <= S_RST_W;
        end
        S_RST_W: if (xfer_done) begin
          res_code  <= RES_FAIL;
          res_valid <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ftp_chk.sv
module ftp_chk #(
  parameter int         DW      = 8,
  parameter logic [7:0] RST_CMD = 8'hF0
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          abort,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic [1:0]    res_code,
  input logic          res_valid
);
  logic wr_seen;
  always_ff @(posedge clk) begin
    if (rst || abort || (start && res_code != 2'b01)) wr_seen <= 1'b0;
    else if (mem_req && mem_we && mem_ack)            wr_seen <= 1'b1;
  end

  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && !abort |=> mem_req && $stable(mem_we) && $stable(mem_wdata));
  a_r5_cmd_value: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata == DW'(RST_CMD));
  a_r5_fail_after_write: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_code == 2'b11 |-> wr_seen);
  a_r2_pass_no_write: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_code == 2'b10 |-> !wr_seen);
  a_r7_abort_idle: assert property (@(posedge clk) disable iff (rst)
    abort |=> !mem_req && res_code == 2'b00 && !res_valid);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  a_r3_req_when_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> res_code == 2'b01);
endmodule

bind flash_tgl_poller ftp_chk #(.DW(DW), .RST_CMD(RST_CMD)) chk_i (
  .clk(clk), .rst(rst), .start(start), .abort(abort),
  .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .res_code(res_code), .res_valid(res_valid)
);

// File: tb/flash_tgl_poller_tb.sv
`timescale 1ns/1ps
module flash_tgl_poller_tb_top;
  localparam int DW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          abort = 1'b0;
  logic [CW-1:0] max_polls = '0;
  logic          mem_req, mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;
  logic [1:0]    res_code;
  logic          res_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0] sq [0:31];
  int rd_idx = 0;
  int wr_cnt = 0;
  logic [7:0] last_w = '0;
  logic [1:0] got_code;

  always #2 clk = ~clk;

  flash_tgl_poller #(.DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .max_polls(max_polls),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .res_code(res_code), .res_valid(res_valid)
  );

  // Memory model: acknowledges each request one half cycle after seeing it
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        wr_cnt = wr_cnt + 1;
        last_w = mem_wdata;
      end else begin
        mem_rdata = sq[rd_idx % 32];
        rd_idx = rd_idx + 1;
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung act=%0d exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(string req, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 32; i++) sq[i] = v;
  endtask

  // Pulse start, optionally check busy code and re-pulse start mid-run, wait for done
  task automatic run(input bit chk_busy, input bit restart_mid);
    rd_idx = 0;
    wr_cnt = 0;
    last_w = '0;
    got_code = 2'b00;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (chk_busy) chk("R3 busy code while active", int'(res_code), 1);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (restart_mid && k == 5) start = 1'b1;
      if (restart_mid && k == 6) start = 1'b0;
      if (res_valid) begin
        got_code = res_code;
        break;
      end
      if (k == 2999) chk("run completes", 0, 1);
    end
  endtask

  task automatic t_reset();
    chk("R1 req after reset", int'(mem_req), 0);
    chk("R1 code after reset", int'(res_code), 0);
    chk("R1 valid after reset", int'(res_valid), 0);
  endtask

  task automatic t_quick_pass();
    fill(8'h40);
    max_polls = '0;
    run(1'b0, 1'b0);
    chk("R2 pass code", int'(got_code), 2);
    chk("R2 two reads", rd_idx, 2);
    chk("R2 no write", wr_cnt, 0);
    @(negedge clk);
    chk("R2 strobe one cycle", int'(res_valid), 0);
    repeat (4) @(negedge clk);
    chk("R9 code held after done", int'(res_code), 2);
  endtask

  task automatic t_running();
    fill(8'h00);
    for (int i = 0; i < 6; i++) sq[i] = (i % 2 == 1) ? 8'h40 : 8'h00;
    max_polls = '0;
    run(1'b1, 1'b1);
    chk("R3 pass after toggling pairs", int'(got_code), 2);
    chk("R3 R9 read count", rd_idx, 8);
    chk("R3 no write", wr_cnt, 0);
  endtask

  task automatic t_recheck_pass();
    fill(8'h20);
    sq[0] = 8'h00; sq[1] = 8'h60;
    max_polls = 16'd1;
    run(1'b0, 1'b0);
    chk("R4 pass after confirm", int'(got_code), 2);
    chk("R4 four reads", rd_idx, 4);
    chk("R4 no write", wr_cnt, 0);
  endtask

  task automatic t_recheck_fail();
    fill(8'h20);
    sq[0] = 8'h00; sq[1] = 8'h60; sq[2] = 8'h20; sq[3] = 8'h60;
    max_polls = '0;
    run(1'b0, 1'b0);
    chk("R5 fail code", int'(got_code), 3);
    chk("R5 four reads", rd_idx, 4);
    chk("R5 one write", wr_cnt, 1);
    chk("R5 write data", int'(last_w), 8'hF0);
  endtask

  task automatic t_limit();
    for (int i = 0; i < 32; i++) sq[i] = (i % 2 == 1) ? 8'h40 : 8'h00;
    max_polls = 16'd3;
    run(1'b0, 1'b0);
    chk("R8 fail at limit", int'(got_code), 3);
    chk("R8 reads at limit", rd_idx, 6);
    chk("R8 reset write", wr_cnt, 1);
    for (int i = 0; i < 32; i++) sq[i] = (i % 2 == 1) ? 8'h40 : 8'h00;
    sq[16] = 8'h00; sq[17] = 8'h00;
    max_polls = '0;
    run(1'b0, 1'b0);
    chk("R8 unlimited pass", int'(got_code), 2);
    chk("R8 unlimited reads", rd_idx, 18);
  endtask

  task automatic t_noise();
    fill(8'h00);
    sq[0] = 8'h9F; sq[1] = 8'h90;
    max_polls = '0;
    run(1'b0, 1'b0);
    chk("R10 other bits ignored", int'(got_code), 2);
    chk("R10 reads", rd_idx, 2);
  endtask

  task automatic t_abort();
    fill(8'h40);
    sq[0] = 8'h40; sq[1] = 8'h00;
    max_polls = '0;
    rd_idx = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (rd_idx < 1) @(negedge clk);
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    chk("R7 req low after abort", int'(mem_req), 0);
    chk("R7 idle code after abort", int'(res_code), 0);
    repeat (3) @(negedge clk);
    fill(8'h00);
    sq[0] = 8'h00; sq[1] = 8'h00;
    run(1'b0, 1'b0);
    chk("R7 fresh pass", int'(got_code), 2);
    chk("R7 fresh pair of reads", rd_idx, 2);
  endtask

  initial begin
    fill(8'h00);
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);
    t_quick_pass();
    t_running();
    t_recheck_pass();
    t_recheck_fail();
    t_limit();
    t_noise();
    t_abort();
    repeat (4) @(negedge clk);
    summary();
  end
endmodule